// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two Write Port

This block is the write half of a quad-data-rate synchronous memory, with a small behavioural array included. It runs on a pair of complementary clocks, `k` and `k_n`. A write command is an active-low select seen at a rising edge of `k`. The word presented with that command is the first data beat. The word presented at the next rising edge of `k_n` is the second beat. The write address follows on the bus one `k` cycle after the command.

Each beat carries its own active-low lane mask, one bit per 9-bit lane. At the `k` edge that samples the address, the two beats are merged into two adjacent array words: the even word first, then the odd word. Commands may arrive on every `k` edge, so data moves on every edge of both clocks. When the select is high the port is deselected and ignores the bus. A combinational read-back port exposes any array word for checking.

Top module: `qdrw_write_port`

## Requirements
- R1: A write command is taken when `w_n` is 0 at a rising edge of `k`. The `d` and `bw_n` values at that same edge form the first beat.
- R2: The second beat is the `d` and `bw_n` values at the next rising edge of `k_n`, which is half a `k` period later.
- R3: The write address is the value on `addr` at the `k` rising edge one cycle after the command. The first beat goes to the word with address bit 0 cleared, and the second beat goes to the word with address bit 0 set.
- R4: Commands may be issued on consecutive `k` edges. Each burst is then committed in full, in the order issued.
- R5: A `k` edge with `w_n` at 1 starts no write, and the data and masks on the bus in that cycle change no array word.
- R6: For each beat, `bw_n[i]` at 0 writes bits 9i to 9i+8 of the target word. `bw_n[i]` at 1 leaves those bits unchanged.
- R7: The two beats of one burst use independent masks, each sampled with its own beat.
- R8: Both array words are updated at the `k` rising edge that follows the command, and `rb_data` shows the new contents from then on.
- R9: While `rst_n` is 0 the pending command is dropped, and the array contents are kept. Reset takes effect at once and ends two `k` edges after `rst_n` rises.
- R10: `rb_data` always shows the array word at `rb_addr`, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Command and first-beat clock |
| k_n | input | 1 | Complement of `k`; its rising edge samples the second beat |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| w_n | input | 1 | Active-low write select |
| addr | input | ADDR_W | Word address, presented one `k` cycle after its command |
| d | input | DATA_W | Write data, one beat per clock edge |
| bw_n | input | DATA_W/9 | Active-low lane write enables, one per 9-bit lane |
| rb_addr | input | ADDR_W | Read-back word address |
| rb_data | output | DATA_W | Read-back word at `rb_addr` |

## Verification
A command placed at `k` edge n first changes the array at edge n+1. Because the read-back path is combinational, both target words can be observed a quarter period after edge n+1. The bench drives inputs a quarter period after each edge of `k`. It sets `rb_addr` and samples `rb_data` a quarter period after the committing `k` edge, which keeps every sample clear of both clock edges. The embedded properties check the same one-edge delay: a word read across a non-committing edge must stay unchanged, and a fully enabled beat must appear one edge after its commit.

// File: rtl/qdrw_pkg.sv
package qdrw_pkg;
  localparam int unsigned LANE_W = 9;

  // the two halves of a burst
  typedef enum logic {BEAT_EVEN = 1'b0, BEAT_ODD = 1'b1} beat_e;
endpackage

// File: rtl/qdrw_rst_sync.sv
module qdrw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/qdrw_capture.sv
module qdrw_capture
  import qdrw_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              k,
  input  logic              k_n,
  input  logic              srst_n,
  input  logic              w_n,
  input  logic [DATA_W-1:0] d,
  input  logic [LANES-1:0]  bw_n,
  output logic              pend,
  output logic [DATA_W-1:0] even_data,
  output logic [LANES-1:0]  even_mask_n,
  output logic [DATA_W-1:0] odd_data,
  output logic [LANES-1:0]  odd_mask_n
);
  logic              pend_q, pend_d;
  logic              even_en, odd_en;
  logic [DATA_W-1:0] even_d_q, odd_d_q;
  logic [LANES-1:0]  even_m_q, odd_m_q;

  // first beat: same k edge as the command
  always_comb begin
    pend_d  = ~w_n;
    even_en = ~w_n;
  end

  always_ff @(posedge k or negedge srst_n) begin
    if (!srst_n) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge k) begin
    if (even_en) begin
      even_d_q <= d;
      even_m_q <= bw_n;
    end
  end

  // second beat: k_n edge following the command
  always_comb begin
    odd_en = pend_q;
  end

  always_ff @(posedge k_n) begin
    if (odd_en) begin
      odd_d_q <= d;
      odd_m_q <= bw_n;
    end
  end

  assign pend        = pend_q;
  assign even_data   = even_d_q;
  assign even_mask_n = even_m_q;
  assign odd_data    = odd_d_q;
  assign odd_mask_n  = odd_m_q;
endmodule

// File: rtl/qdrw_array.sv
module qdrw_array
  import qdrw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 36,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa_even,
  input  logic [DATA_W-1:0] wd_even,
  input  logic [LANES-1:0]  wm_even_n,
  input  logic [ADDR_W-1:0] wa_odd,
  input  logic [DATA_W-1:0] wd_odd,
  input  logic [LANES-1:0]  wm_odd_n,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  // one storage column per lane, so lane enables never share a driver
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] col [DEPTH];
    logic              even_we, odd_we;

    always_comb begin
      even_we = we & ~wm_even_n[g];
      odd_we  = we & ~wm_odd_n[g];
    end

    always_ff @(posedge clk) begin
      if (even_we) col[wa_even] <= wd_even[g*LANE_W +: LANE_W];
      if (odd_we)  col[wa_odd]  <= wd_odd[g*LANE_W +: LANE_W];
    end

    assign rd[g*LANE_W +: LANE_W] = col[ra];
  end
endmodule

// File: rtl/qdrw_write_port.sv
module qdrw_write_port
  import qdrw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 36
) (
  input  logic                       k,
  input  logic                       k_n,
  input  logic                       rst_n,
  input  logic                       w_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          d,
  input  logic [DATA_W/LANE_W-1:0]   bw_n,
  input  logic [ADDR_W-1:0]          rb_addr,
  output logic [DATA_W-1:0]          rb_data
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic              srst_n;
  logic              pend;
  logic [DATA_W-1:0] even_data, odd_data;
  logic [LANES-1:0]  even_mask_n, odd_mask_n;
  logic [ADDR_W-1:0] wa_even, wa_odd;

  qdrw_rst_sync #(.STAGES(2)) u_rst (
    .clk(k), .arst_n(rst_n), .srst_n(srst_n)
  );

  qdrw_capture #(.DATA_W(DATA_W)) u_cap (
    .k(k), .k_n(k_n), .srst_n(srst_n), .w_n(w_n), .d(d), .bw_n(bw_n),
    .pend(pend), .even_data(even_data), .even_mask_n(even_mask_n),
    .odd_data(odd_data), .odd_mask_n(odd_mask_n)
  );

  // pair of word addresses from the late address bus
  always_comb begin
    wa_even = {addr[ADDR_W-1:1], BEAT_EVEN};
    wa_odd  = {addr[ADDR_W-1:1], BEAT_ODD};
  end

  qdrw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(k), .we(pend),
    .wa_even(wa_even), .wd_even(even_data), .wm_even_n(even_mask_n),
    .wa_odd(wa_odd), .wd_odd(odd_data), .wm_odd_n(odd_mask_n),
    .ra(rb_addr), .rd(rb_data)
  );

  // no commit across an edge: the observed word keeps its value
  assert_no_write_when_idle_R5: assert property (@(posedge k) disable iff (!srst_n)
    !pend |=> (rb_addr != $past(rb_addr)) || $stable(rb_data));

  // fully enabled first beat lands on the even word one edge later
  assert_even_beat_lands_R3: assert property (@(posedge k) disable iff (!srst_n)
    (pend && even_mask_n == '0 && rb_addr == {addr[ADDR_W-1:1], 1'b0})
      |=> (rb_addr != $past(rb_addr)) || (rb_data == $past(even_data)));

  // fully enabled second beat lands on the odd word one edge later
  assert_odd_beat_lands_R2: assert property (@(posedge k) disable iff (!srst_n)
    (pend && odd_mask_n == '0 && rb_addr == {addr[ADDR_W-1:1], 1'b1})
      |=> (rb_addr != $past(rb_addr)) || (rb_data == $past(odd_data)));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // masked lanes of either beat are left untouched
    assert_masked_even_lane_kept_R6: assert property (@(posedge k) disable iff (!srst_n)
      (pend && even_mask_n[g] && rb_addr == {addr[ADDR_W-1:1], 1'b0})
        |=> (rb_addr != $past(rb_addr)) ||
            $stable(rb_data[g*LANE_W +: LANE_W]));
    assert_masked_odd_lane_kept_R7: assert property (@(posedge k) disable iff (!srst_n)
      (pend && odd_mask_n[g] && rb_addr == {addr[ADDR_W-1:1], 1'b1})
        |=> (rb_addr != $past(rb_addr)) ||
            $stable(rb_data[g*LANE_W +: LANE_W]));
  end
endmodule

// File: tb/qdrw_write_port_test.sv
module qdrw_write_port_test;
  localparam int CLK_PERIOD = 20;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int AW         = 6;
  localparam int DW         = 36;
  localparam int NL         = DW / 9;
  localparam int WORDS      = 1 << AW;

  logic          k, k_n, rst_n, w_n;
  logic [AW-1:0] addr, rb_addr;
  logic [DW-1:0] d, rb_data;
  logic [NL-1:0] bw_n;

  int checks = 0;
  int fails  = 0;

  qdrw_write_port #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .k(k), .k_n(k_n), .rst_n(rst_n), .w_n(w_n), .addr(addr), .d(d),
    .bw_n(bw_n), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  initial begin
    k = 1'b0;
    forever #(CLK_PERIOD/2) k = ~k;
  end
  assign k_n = ~k;

  typedef struct packed {
    logic          wn;
    logic [AW-1:0] a;
    logic [DW-1:0] d0;
    logic [NL-1:0] m0;
    logic [DW-1:0] d1;
    logic [NL-1:0] m1;
  } vec_t;

  // expected words come from the shadow model driven by these rows
  localparam vec_t VECS [12] = '{
    '{1'b0, 6'd2,  36'h123456789, 4'h0, 36'hFEDCBA987, 4'h0}, // R1 R2 full burst
    '{1'b0, 6'd5,  36'hAAAAAAAAA, 4'h0, 36'h555555555, 4'h0}, // R3 odd addr, R4 back-to-back
    '{1'b0, 6'd5,  36'h0F0F0F0F0, 4'hE, 36'hF0F0F0F0F, 4'h7}, // R6 one lane each
    '{1'b1, 6'd9,  36'hDEADBEEF1, 4'h0, 36'hBADC0FFEE, 4'h0}, // R5 junk on deselect
    '{1'b0, 6'd8,  36'h111111111, 4'h5, 36'h222222222, 4'hA}, // R7 differing masks
    '{1'b0, 6'd9,  36'h333333333, 4'hF, 36'h444444444, 4'h0}, // R7 first beat fully masked
    '{1'b0, 6'd12, 36'h0000000FF, 4'h3, 36'hFF0000000, 4'hC}, // R6 upper vs lower lanes
    '{1'b1, 6'd12, 36'hFFFFFFFFF, 4'h0, 36'hFFFFFFFFF, 4'h0}, // R5
    '{1'b1, 6'd0,  36'h000000000, 4'h0, 36'h000000000, 4'h0}, // R5
    '{1'b0, 6'd63, 36'h876543210, 4'h0, 36'h013579BDF, 4'h0}, // R3 top pair
    '{1'b0, 6'd0,  36'h24680ACE1, 4'h9, 36'h97531FDB2, 4'h6}, // R4 R7
    '{1'b0, 6'd63, 36'hC3C3C3C3C, 4'hB, 36'h3C3C3C3C3, 4'hD}  // R6 overwrite
  };

  logic [DW-1:0] shadow [WORDS];
  logic          pend;
  logic [AW-1:0] p_a;
  logic [DW-1:0] p_d0, p_d1;
  logic [NL-1:0] p_m0, p_m1;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nd,
                                          input logic [NL-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NL; i++)
      if (!m[i]) r[i*9 +: 9] = nd[i*9 +: 9];
    return r;
  endfunction

  task automatic check_word(input logic [AW-1:0] a, input string rq);
    rb_addr = a;
    #1;
    checks++;
    if (rb_data !== shadow[a]) begin
      fails++;
      $display("FAIL %s word %0d: got %h expected %h", rq, a, rb_data, shadow[a]);
    end
  endtask

  // one k period: command/first beat, commit of the previous command, second beat
  task automatic cycle(input logic wn, input logic [AW-1:0] a,
                       input logic [DW-1:0] x0, input logic [NL-1:0] k0,
                       input logic [DW-1:0] x1, input logic [NL-1:0] k1);
    logic          did;
    logic [AW-1:0] ce;
    @(negedge k); #(Q);
    w_n  = wn;
    d    = x0;
    bw_n = k0;
    addr = pend ? p_a : AW'($urandom);
    @(posedge k);
    did = pend;
    ce  = {p_a[AW-1:1], 1'b0};
    if (pend) begin
      shadow[ce]        = merge(shadow[ce], p_d0, p_m0);
      shadow[ce | 'd1]  = merge(shadow[ce | 'd1], p_d1, p_m1);
    end
    pend = !wn;
    p_a = a; p_d0 = x0; p_m0 = k0; p_d1 = x1; p_m1 = k1;
    #(Q);
    d    = x1;
    bw_n = k1;
    if (did) begin
      check_word(ce, "R8 R1 R3 even word");
      check_word(ce | 'd1, "R8 R2 R3 odd word");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cycle(1'b1, AW'($urandom), {$urandom, $urandom}, NL'($urandom),
            {$urandom, $urandom}, NL'($urandom));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; w_n = 1'b1; addr = '0; d = '0; bw_n = '1; rb_addr = '0;
    pend = 1'b0; p_a = '0; p_d0 = '0; p_d1 = '0; p_m0 = '0; p_m1 = '0;
    repeat (3) @(posedge k);
    @(negedge k); #(Q); rst_n = 1'b1;
    idle(3);

    // fill every word with full-mask bursts (R4 back-to-back)
    for (int i = 0; i < WORDS; i += 2)
      cycle(1'b0, AW'(i), {4'h0, 32'(i * 7 + 1)}, '0, {4'hF, 32'(i * 13 + 5)}, '0);
    idle(1);

    // vector table
    for (int i = 0; i < 12; i++)
      cycle(VECS[i].wn, VECS[i].a, VECS[i].d0, VECS[i].m0, VECS[i].d1, VECS[i].m1);
    idle(1);

    // R10 full read-back sweep
    for (int i = 0; i < WORDS; i++) begin
      @(negedge k); #(Q);
      check_word(AW'(i), "R10 sweep");
    end

    // R5: deselect cycles with junk data and all lanes enabled
    for (int i = 0; i < 6; i++)
      cycle(1'b1, AW'(i * 11), {$urandom, $urandom}, '0, {$urandom, $urandom}, '0);
    for (int i = 0; i < WORDS; i += 5) begin
      @(negedge k); #(Q);
      check_word(AW'(i), "R5 after deselect");
    end

    // R9: reset while a command is pending drops it, array kept
    cycle(1'b0, 6'd20, 36'h5A5A5A5A5, '0, 36'hA5A5A5A5A, '0);
    @(negedge k); #(Q);
    rst_n = 1'b0; w_n = 1'b1; addr = 6'd20; pend = 1'b0;
    repeat (2) @(posedge k);
    @(negedge k); #(Q); rst_n = 1'b1;
    idle(3);
    check_word(6'd20, "R9 dropped even");
    check_word(6'd21, "R9 dropped odd");
    cycle(1'b0, 6'd21, 36'h0CAFE0123, '0, 36'h0BEEF0456, 4'h1);
    idle(1);

    // randomised bursts, deselects and masks
    for (int i = 0; i < 150; i++)
      cycle(($urandom % 4) == 0, AW'($urandom), {$urandom, $urandom}, NL'($urandom),
            {$urandom, $urandom}, NL'($urandom));
    idle(1);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge k); #(Q);
      check_word(AW'(i), "R6 R7 random final");
    end

    summary();
    $finish;
  end
endmodule